// File: doc/BRIEF.md
# Supply supervisor reset sequencer

This block sits between a set of already-digitized supply-monitor flags and a processor. It turns a "supply above reset threshold" flag, a "supply below backup battery" flag, a power-fail comparator flag and a watchdog-expiry strobe into the processor-facing status outputs. These are an active-low reset and its active-high complement, a low-line flag, a battery-on flag, a power-fail warning and a gated chip-enable for battery-backed memory. All time is counted in cycles of the timebase clock that drives the block.

A single stretch counter serves two causes of reset. The first is a brownout, where the supply is invalid or below the battery. The second is a watchdog expiry. When reset ends, the block emits a one-cycle pulse so that an external watchdog can restart its timer. While the supply is below the battery, every output is forced to a fixed safe state, and the power-fail and chip-enable inputs have no effect. Every output is registered, so it reflects the inputs sampled at the previous rising clock edge.

Top module: `supv_reset_seq`

## Requirements
- R1: At every rising edge where `vcc_ok_i` is 0 or `below_batt_i` is 1 (supply invalid), `rst_n_o` is 0 after that edge.
- R2: After the first edge that samples a valid supply, `rst_n_o` stays 0 for exactly W cycles and then goes to 1. W is SHORT_CYCLES when `long_sel_i` was 0, and LONG_CYCLES when it was 1, at the last edge that sampled an invalid supply. A later change of `long_sel_i` does not alter a stretch that is already running.
- R3: A `wd_expire_i` strobe sampled while the supply is valid and `rst_n_o` is 1 makes `rst_n_o` 0 for exactly W cycles. W is chosen by `long_sel_i` at that edge.
- R4: `lowline_n_o` is 1 after an edge exactly when that edge sampled `vcc_ok_i`=1 and `below_batt_i`=0. It is not stretched.
- R5: `rst_o` is always the inverse of `rst_n_o`.
- R6: `ce_n_o` follows `ce_n_i` (sampled one edge earlier) while the supply is valid. It is 1 whenever the supply is invalid.
- R7: With `below_batt_i`=1, after the edge the outputs are `rst_n_o`=0, `rst_o`=1, `lowline_n_o`=0, `batt_on_o`=1, `pf_n_o`=0 and `ce_n_o`=1, whatever the values of `pwr_low_i` and `ce_n_i`.
- R8: With `below_batt_i`=0, `pf_n_o` is the inverse of `pwr_low_i` sampled one edge earlier. Here `pwr_low_i`=1 means the monitored input is below its reference.
- R9: `batt_on_o` equals `below_batt_i` sampled one edge earlier.
- R10: A `wd_expire_i` strobe sampled while `rst_n_o` is 0 is ignored. This includes the edge on which reset ends, and it covers strobes during a stretch and during an invalid supply: the pulse is neither extended nor restarted.
- R11: A supply drop during a watchdog-caused pulse holds reset for as long as the drop lasts. A full stretch as in R2 then follows recovery.
- R12: `rst_done_o` is 1 for exactly one cycle, the first cycle in which `rst_n_o` is 1 after being 0.
- R13: While `rst_n_i` is 0 the outputs are `rst_n_o`=0, `rst_o`=1, `lowline_n_o`=0, `batt_on_o`=0, `pf_n_o`=0, `ce_n_o`=1 and `rst_done_o`=0. With a valid supply after release, reset lasts LONG_CYCLES cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timebase clock |
| rst_n_i | input | 1 | Asynchronous block reset, active low |
| vcc_ok_i | input | 1 | Supply above reset threshold |
| below_batt_i | input | 1 | Supply below battery (backup mode) |
| pwr_low_i | input | 1 | Power-fail comparator: input below reference |
| wd_expire_i | input | 1 | Watchdog expiry strobe |
| ce_n_i | input | 1 | Chip-enable to be gated, active low |
| long_sel_i | input | 1 | 0 selects short reset width, 1 long |
| rst_n_o | output | 1 | Processor reset, active low |
| rst_o | output | 1 | Processor reset, active high |
| lowline_n_o | output | 1 | Low-line flag, active low |
| batt_on_o | output | 1 | Running from battery |
| pf_n_o | output | 1 | Power-fail warning, active low |
| ce_n_o | output | 1 | Gated chip-enable, active low |
| rst_done_o | output | 1 | One-cycle pulse when reset ends |

## Verification
A watchdog strobe and a reset-related event can land in the same cycle. The bench provokes this in three ways: it raises the strobe on the same edge that the supply goes invalid, on the exact edge where the stretch counter releases reset, and in the middle of a running pulse. Each case is judged by counting the low samples of `rst_n_o` and comparing the count with the width computed from the mode. The strobe must neither lengthen the pulse nor start a second one. The reverse case, a supply drop during a watchdog pulse, is judged by requiring a full stretch counted from recovery.

// File: rtl/supv_pkg.sv
package supv_pkg;

   // registered status flags other than reset, MSB first
   typedef struct packed {
      logic lowline_n;
      logic batt_on;
      logic pf_n;
      logic ce_n;
   } supv_stat_t;

   localparam int unsigned STAT_W = $bits(supv_stat_t);

   // safe values held while the block itself is in reset
   localparam supv_stat_t STAT_RST = '{lowline_n: 1'b0, batt_on: 1'b0,
                                       pf_n: 1'b0, ce_n: 1'b1};

   function automatic int unsigned cnt_bits(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/supv_stretch.sv
module supv_stretch #(
   parameter int unsigned SHORT_CYCLES = 512,
   parameter int unsigned LONG_CYCLES  = 2048
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic supply_bad_i,
   input  logic wd_expire_i,
   input  logic long_sel_i,
   output logic act_o,
   output logic done_o
);
   import supv_pkg::*;

   localparam int unsigned CNT_W = cnt_bits(LONG_CYCLES);
   localparam logic [CNT_W-1:0] SHORT_V = CNT_W'(SHORT_CYCLES);
   localparam logic [CNT_W-1:0] LONG_V  = CNT_W'(LONG_CYCLES);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] width_w;
   logic             act_q;
   logic             done_q;

   assign width_w = long_sel_i ? LONG_V : SHORT_V;

   // brownout reloads the full width every cycle it lasts; the watchdog
   // loads one less because its strobe edge already counts as a low cycle
   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         act_q  <= 1'b1;
         cnt_q  <= LONG_V;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (supply_bad_i) begin
            act_q <= 1'b1;
            cnt_q <= width_w;
         end else if (act_q) begin
            if (cnt_q == '0) begin
               act_q  <= 1'b0;
               done_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end else if (wd_expire_i) begin
            act_q <= 1'b1;
            cnt_q <= width_w - 1'b1;
         end
      end
   end

   assign act_o  = act_q;
   assign done_o = done_q;

endmodule

// File: rtl/supv_status_dec.sv
module supv_status_dec (
   input  logic                 vcc_ok_i,
   input  logic                 below_batt_i,
   input  logic                 pwr_low_i,
   input  logic                 ce_n_i,
   output logic                 supply_bad_o,
   output supv_pkg::supv_stat_t stat_o
);
   always_comb begin
      supply_bad_o     = !vcc_ok_i || below_batt_i;
      stat_o.lowline_n = vcc_ok_i && !below_batt_i;
      stat_o.batt_on   = below_batt_i;
      stat_o.pf_n      = !below_batt_i && !pwr_low_i;
      stat_o.ce_n      = supply_bad_o || ce_n_i;
   end
endmodule

// File: rtl/supv_flop_bank.sv
module supv_flop_bank #(
   parameter int unsigned     W       = 4,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk_i,
   input  logic         rst_n_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   for (genvar b = 0; b < W; b++) begin : g_bit
      always_ff @(posedge clk_i or negedge rst_n_i) begin
         if (!rst_n_i) q_o[b] <= RST_VAL[b];
         else          q_o[b] <= d_i[b];
      end
   end
endmodule

// File: rtl/supv_reset_seq.sv
module supv_reset_seq #(
   parameter int unsigned SHORT_CYCLES = 512,
   parameter int unsigned LONG_CYCLES  = 2048
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic vcc_ok_i,
   input  logic below_batt_i,
   input  logic pwr_low_i,
   input  logic wd_expire_i,
   input  logic ce_n_i,
   input  logic long_sel_i,
   output logic rst_n_o,
   output logic rst_o,
   output logic lowline_n_o,
   output logic batt_on_o,
   output logic pf_n_o,
   output logic ce_n_o,
   output logic rst_done_o
);
   import supv_pkg::*;

   if (SHORT_CYCLES < 2) begin : g_chk_short
      $error("SHORT_CYCLES must be at least 2");
   end
   if (LONG_CYCLES < SHORT_CYCLES) begin : g_chk_long
      $error("LONG_CYCLES must not be below SHORT_CYCLES");
   end

   logic       supply_bad_w;
   logic       act_w;
   supv_stat_t stat_d_w;
   supv_stat_t stat_q_w;

   supv_status_dec dec_i (
      .vcc_ok_i     (vcc_ok_i),
      .below_batt_i (below_batt_i),
      .pwr_low_i    (pwr_low_i),
      .ce_n_i       (ce_n_i),
      .supply_bad_o (supply_bad_w),
      .stat_o       (stat_d_w)
   );

   supv_stretch #(
      .SHORT_CYCLES (SHORT_CYCLES),
      .LONG_CYCLES  (LONG_CYCLES)
   ) stretch_i (
      .clk_i        (clk_i),
      .rst_n_i      (rst_n_i),
      .supply_bad_i (supply_bad_w),
      .wd_expire_i  (wd_expire_i),
      .long_sel_i   (long_sel_i),
      .act_o        (act_w),
      .done_o       (rst_done_o)
   );

   supv_flop_bank #(
      .W       (STAT_W),
      .RST_VAL (STAT_RST)
   ) stat_reg_i (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .d_i     (stat_d_w),
      .q_o     (stat_q_w)
   );

   assign rst_n_o     = !act_w;
   assign rst_o       = act_w;
   assign lowline_n_o = stat_q_w.lowline_n;
   assign batt_on_o   = stat_q_w.batt_on;
   assign pf_n_o      = stat_q_w.pf_n;
   assign ce_n_o      = stat_q_w.ce_n;

endmodule

// File: rtl/supv_reset_seq_chk.sv
module supv_reset_seq_chk #(
   parameter int unsigned SHORT_CYCLES = 512,
   parameter int unsigned LONG_CYCLES  = 2048
) (
   input logic clk_i,
   input logic rst_n_i,
   input logic vcc_ok_i,
   input logic below_batt_i,
   input logic pwr_low_i,
   input logic wd_expire_i,
   input logic ce_n_i,
   input logic rst_n_o,
   input logic rst_o,
   input logic lowline_n_o,
   input logic batt_on_o,
   input logic pf_n_o,
   input logic ce_n_o,
   input logic rst_done_o
);
   localparam int unsigned GAP_W = supv_pkg::cnt_bits(LONG_CYCLES + 2) + 1;

   logic             bad_w;
   logic [GAP_W-1:0] gap_q;

   assign bad_w = !vcc_ok_i || below_batt_i;

   // cycles since the last edge that saw an invalid supply, saturating
   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)             gap_q <= '0;
      else if (bad_w)           gap_q <= '0;
      else if (gap_q != '1)     gap_q <= gap_q + 1'b1;
   end

   AST_BAD_HOLDS_RESET: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      bad_w |=> !rst_n_o);                                                     // R1
   AST_NO_EARLY_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $rose(rst_n_o) |-> (gap_q > GAP_W'(SHORT_CYCLES)));                      // R2
   AST_WD_STARTS_PULSE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (wd_expire_i && !bad_w && rst_n_o) |=> !rst_n_o);                        // R3
   AST_LOWLINE_UP: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !bad_w |=> lowline_n_o);                                                 // R4
   AST_LOWLINE_DOWN: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      bad_w |=> !lowline_n_o);                                                 // R4
   AST_CE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !bad_w |=> (ce_n_o == $past(ce_n_i)));                                   // R6
   AST_CE_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      bad_w |=> ce_n_o);                                                       // R6
   AST_BATT_SAFE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      below_batt_i |=> (!rst_n_o && rst_o && batt_on_o && !lowline_n_o
                        && !pf_n_o && ce_n_o));                                // R7
   AST_PF_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !below_batt_i |=> (pf_n_o == !$past(pwr_low_i)));                        // R8
   AST_DONE_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $rose(rst_n_o) |-> rst_done_o);                                          // R12
   AST_DONE_ONLY_RISE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      rst_done_o |-> $rose(rst_n_o));                                          // R12

endmodule

bind supv_reset_seq supv_reset_seq_chk #(
   .SHORT_CYCLES (SHORT_CYCLES),
   .LONG_CYCLES  (LONG_CYCLES)
) chk_i (
   .clk_i        (clk_i),
   .rst_n_i      (rst_n_i),
   .vcc_ok_i     (vcc_ok_i),
   .below_batt_i (below_batt_i),
   .pwr_low_i    (pwr_low_i),
   .wd_expire_i  (wd_expire_i),
   .ce_n_i       (ce_n_i),
   .rst_n_o      (rst_n_o),
   .rst_o        (rst_o),
   .lowline_n_o  (lowline_n_o),
   .batt_on_o    (batt_on_o),
   .pf_n_o       (pf_n_o),
   .ce_n_o       (ce_n_o),
   .rst_done_o   (rst_done_o)
);

// File: tb/supv_reset_seq_tb_top.sv
module supv_reset_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int SHORT_W    = 6;
   localparam int LONG_W     = 20;
   localparam int WATCHDOG   = 200000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic vcc_ok = 1'b1, below_batt = 1'b0, pwr_low = 1'b0;
   logic wd = 1'b0, ce_n = 1'b1, long_sel = 1'b0;
   logic rst_n_o, rst_o, lowline_n_o, batt_on_o, pf_n_o, ce_n_o, rst_done_o;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   supv_reset_seq #(.SHORT_CYCLES(SHORT_W), .LONG_CYCLES(LONG_W)) dut_i (
      .clk_i(clk), .rst_n_i(rst_n), .vcc_ok_i(vcc_ok), .below_batt_i(below_batt),
      .pwr_low_i(pwr_low), .wd_expire_i(wd), .ce_n_i(ce_n), .long_sel_i(long_sel),
      .rst_n_o(rst_n_o), .rst_o(rst_o), .lowline_n_o(lowline_n_o),
      .batt_on_o(batt_on_o), .pf_n_o(pf_n_o), .ce_n_o(ce_n_o),
      .rst_done_o(rst_done_o));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int width_of(input logic m);
      return m ? LONG_W : SHORT_W;
   endfunction

   // counts low samples from the current one on, then checks the release pulse
   task automatic finish_count(input int pre, input int expw, input string req);
      int n = pre;
      int guard = 0;
      while (rst_n_o === 1'b0 && guard < 1000) begin
         n++; guard++;
         chk(rst_o === 1'b1, "R5", rst_o, 1);
         @(negedge clk);
      end
      chk(n == expw, req, n, expw);
      chk(rst_done_o === 1'b1, "R12", rst_done_o, 1);
      chk(rst_o === 1'b0, "R5", rst_o, 0);
      @(negedge clk);
      chk(rst_done_o === 1'b0, "R12", rst_done_o, 0);
      chk(rst_n_o === 1'b1, req, rst_n_o, 1);
   endtask

   task automatic wait_high();
      int guard = 0;
      vcc_ok = 1'b1; below_batt = 1'b0; wd = 1'b0;
      @(negedge clk);
      while (rst_n_o !== 1'b1 && guard < 1000) begin guard++; @(negedge clk); end
      @(negedge clk);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R13: state while in reset
      repeat (3) @(negedge clk);
      chk(rst_n_o === 1'b0 && rst_o === 1'b1, "R13", rst_n_o, 0);
      chk(lowline_n_o === 1'b0 && batt_on_o === 1'b0, "R13", lowline_n_o, 0);
      chk(pf_n_o === 1'b0 && ce_n_o === 1'b1, "R13", pf_n_o, 0);
      chk(rst_done_o === 1'b0, "R13", rst_done_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      finish_count(0, LONG_W, "R13");

      // R1, R2: brownout sweep over mode, duration and cause
      for (int m = 0; m < 2; m++)
         for (int d = 1; d <= 3; d++)
            for (int src = 0; src < 2; src++) begin
               long_sel = m[0];
               if (src == 0) vcc_ok = 1'b0; else below_batt = 1'b1;
               repeat (d) begin
                  @(negedge clk);
                  chk(rst_n_o === 1'b0, "R1", rst_n_o, 0);
               end
               vcc_ok = 1'b1; below_batt = 1'b0;
               @(negedge clk);
               finish_count(0, width_of(m[0]), "R2");
            end

      // R2: mode changed after recovery does not alter the running stretch
      long_sel = 1'b1; vcc_ok = 1'b0;
      repeat (2) @(negedge clk);
      vcc_ok = 1'b1; long_sel = 1'b0;
      @(negedge clk);
      finish_count(0, LONG_W, "R2");

      // R3: watchdog pulse in both modes, then quiet
      for (int m = 0; m < 2; m++) begin
         long_sel = m[0]; wd = 1'b1;
         @(negedge clk);
         wd = 1'b0;
         finish_count(0, width_of(m[0]), "R3");
         repeat (3) begin
            @(negedge clk);
            chk(rst_n_o === 1'b1, "R3", rst_n_o, 1);
         end
      end

      // R10: strobe during a running pulse does not extend it
      long_sel = 1'b0; wd = 1'b1;
      @(negedge clk);
      wd = 1'b0;
      @(negedge clk);
      wd = 1'b1;
      @(negedge clk);
      wd = 1'b0;
      finish_count(2, SHORT_W, "R10");

      // R10: strobe on the same edge the supply goes invalid
      vcc_ok = 1'b0; wd = 1'b1;
      @(negedge clk);
      wd = 1'b0;
      @(negedge clk);
      vcc_ok = 1'b1;
      @(negedge clk);
      finish_count(0, SHORT_W, "R10");

      // R10: strobe on the release edge is ignored
      vcc_ok = 1'b0;
      @(negedge clk);
      vcc_ok = 1'b1;
      @(negedge clk);
      repeat (SHORT_W - 1) @(negedge clk);
      chk(rst_n_o === 1'b0, "R10", rst_n_o, 0);
      wd = 1'b1;
      @(negedge clk);
      wd = 1'b0;
      chk(rst_n_o === 1'b1 && rst_done_o === 1'b1, "R10", rst_n_o, 1);
      repeat (2) begin
         @(negedge clk);
         chk(rst_n_o === 1'b1, "R10", rst_n_o, 1);
      end

      // R11: supply drop inside a watchdog pulse, both modes
      for (int m = 0; m < 2; m++) begin
         long_sel = m[0]; wd = 1'b1;
         @(negedge clk);
         wd = 1'b0;
         repeat (2) @(negedge clk);
         vcc_ok = 1'b0;
         repeat (SHORT_W + 2) begin
            @(negedge clk);
            chk(rst_n_o === 1'b0, "R11", rst_n_o, 0);
         end
         vcc_ok = 1'b1;
         @(negedge clk);
         finish_count(0, width_of(m[0]), "R11");
      end

      // R4, R5, R6, R7, R8, R9: exhaustive sweep of the status inputs
      long_sel = 1'b0;
      for (int i = 0; i < 16; i++) begin
         logic v, bb, pl, ci, bad;
         v = i[0]; bb = i[1]; pl = i[2]; ci = i[3];
         bad = !v || bb;
         vcc_ok = v; below_batt = bb; pwr_low = pl; ce_n = ci;
         @(negedge clk);
         chk(lowline_n_o === (v && !bb), "R4", lowline_n_o, int'(v && !bb));
         chk(rst_o === !rst_n_o, "R5", rst_o, int'(!rst_n_o));
         chk(ce_n_o === (bad || ci), "R6", ce_n_o, int'(bad || ci));
         chk(batt_on_o === bb, "R9", batt_on_o, int'(bb));
         if (bb) begin
            chk(pf_n_o === 1'b0, "R7", pf_n_o, 0);
            chk(rst_n_o === 1'b0 && rst_o === 1'b1, "R7", rst_n_o, 0);
         end else begin
            chk(pf_n_o === !pl, "R8", pf_n_o, int'(!pl));
         end
         if (bad) chk(rst_n_o === 1'b0, "R1", rst_n_o, 0);
         wait_high();
      end

      // R6, R8: toggling inputs with a valid supply and reset released
      for (int i = 0; i < 4; i++) begin
         ce_n = i[0]; pwr_low = i[1];
         @(negedge clk);
         chk(ce_n_o === i[0], "R6", ce_n_o, i[0]);
         chk(pf_n_o === !i[1], "R8", pf_n_o, int'(!i[1]));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule